// File: doc/BRIEF.md
# Microstep Excitation Phase Sequencer

This block converts a step clock into winding commands for a two-phase unipolar stepper motor. Every cycle of the system clock `clk` it samples a step input that is synchronous to `clk`, a direction bit, a three-bit mode selector and an enable. It keeps one fine electrical position of 4·2^FRAC_W microsteps per electrical cycle. With the default FRAC_W = 4 that is 64 positions. For each of the two windings it drives an on flag, a polarity and a current level code. An external current chopper turns the level code into a fraction of the reference current.

Five step resolutions share that single position. Changing the resolution therefore moves the rotor by no more than half of the new step. One mode bit selects whether a step occurs on the rising step-input edge only or on both edges. A monitor output pulses once for every electrical revolution. The rest of this brief describes the default FRAC_W = 4. Position p runs from 0 to 63, f = p mod 16 and q = p div 16.

Top module: `ustep_sequencer`

## Requirements
- R1: When mode_sel[2] = 1, a step happens only when step_in is sampled high after being sampled low. mode_sel[1:0] = 0, 1, 2, 3 select step sizes of 16, 8, 4 and 2 positions.
- R2: When mode_sel[2] = 0, every change of the sampled step_in level is a step. mode_sel[1:0] = 0, 1, 2, 3 select step sizes of 8, 4, 2 and 1 positions.
- R3: Each step moves the position by exactly the step size of the current resolution, modulo 64. The finest resolution therefore reaches all 64 positions.
- R4: A winding is decoded from its angle a, with f = a mod 16 and q = a div 16. The index is f when q is odd and 16 − f when q is even. The winding is on when the index is nonzero. Its level code is the index minus 1. Its polarity bit (1 = negative winding) is set for q = 1 or 2. Phase A uses a = p. Phase B uses a = (p − 16) mod 64. The level code is read as the current fraction for index code+1: codes 0 to 15 give 11, 20, 30, 40, 47, 55, 64, 71, 77, 83, 87, 93, 95, 97, 100 and 100 percent. While enabled, at least one winding is on.
- R5: In the two resolutions with mode_sel[2] = 1 and mode_sel[1] = 0, every winding that is on reports level code 15.
- R6: dir_in = 0 adds the step size to the position (forward). dir_in = 1 subtracts it (reverse).
- R7: In every enabled cycle, the position first snaps to the nearest point of the active resolution's grid, with ties going upward. The grid is the multiples of the step size. The 16-position resolution is the exception: its grid is the odd multiples of 8. A step in the same cycle then starts from the snapped point.
- R8: While enable is 0, both windings are off with level 0 and polarity 0. Step edges, direction and mode are ignored, and the position and the level mode are held. A step_in level change made while disabled causes no step after enable returns.
- R9: rst_n = 0 sets position 8 (both windings on, positive, level code 7) and clears the monitor output.
- R10: mon_pulse is high for exactly one cycle, the cycle after a step whose position move wrapped through 0 in either direction.
- R11: Results appear one clock after sampling. The position and the level mode register the inputs sampled at a clock edge, and the winding outputs follow them combinationally, with enable gating them directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step clock, synchronous to clk |
| dir_in | input | 1 | 0 forward, 1 reverse |
| mode_sel | input | 3 | [2] edge select, [1:0] resolution code |
| enable | input | 1 | 1 run, 0 windings off and state frozen |
| pha_neg | output | 1 | Phase A polarity (1 = negative winding) |
| pha_on | output | 1 | Phase A winding energised |
| pha_level | output | FRAC_W | Phase A current level code |
| phb_neg | output | 1 | Phase B polarity (1 = negative winding) |
| phb_on | output | 1 | Phase B winding energised |
| phb_level | output | FRAC_W | Phase B current level code |
| mon_pulse | output | 1 | One-cycle pulse per electrical revolution |

## Verification
The bench first runs every resolution in both step directions with single-edge and double-edge selection. This separates wrong step sizes, a wrong edge choice and a wrong direction sign. Long runs in the finest mode sweep all 64 positions through the level decode, and they cross the wrap point in both directions to expose a misplaced or repeated monitor pulse. Mode switches are then made from positions that sit off the new grid, including exact ties and switches in the same cycle as a step, so that rounding errors and snap-then-step ordering errors show up. Disable windows with step toggles, mode changes and a dangling step_in level show whether anything leaks through the freeze.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
   // step resolution; numeric value n selects a step of 2^(FRAC_W-n) positions
   typedef enum logic [2:0] {
      RES_FULL2 = 3'd0,
      RES_HALF  = 3'd1,
      RES_QTR   = 3'd2,
      RES_EIGHT = 3'd3,
      RES_SIXT  = 3'd4
   } res_e;

   localparam int unsigned NUM_RES  = 5;
   localparam int unsigned NUM_PHASE = 2;
endpackage

// File: rtl/ustep_mode_dec.sv
module ustep_mode_dec
   import ustep_pkg::*;
(
   input  logic [2:0] mode_sel,
   output res_e       res,
   output logic       full_cur,
   output logic       both_edges
);
   always_comb begin
      both_edges = ~mode_sel[2];
      full_cur   = mode_sel[2] & ~mode_sel[1];
      if (mode_sel[2]) res = res_e'({1'b0, mode_sel[1:0]});
      else             res = res_e'({1'b0, mode_sel[1:0]} + 3'd1);
   end
endmodule

// File: rtl/ustep_step_edge.sv
module ustep_step_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic step_in,
   input  logic both_edges,
   input  logic enable,
   output logic fire
);
   logic step_q;

   // history tracks the input even while frozen so no phantom edge appears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= step_in;
   end

   always_comb begin
      if (both_edges) fire = enable & (step_in ^ step_q);
      else            fire = enable & step_in & ~step_q;
   end
endmodule

// File: rtl/ustep_position.sv
module ustep_position
   import ustep_pkg::*;
#(
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fire,
   input  logic              dir_rev,
   input  res_e              res,
   output logic [FRAC_W+1:0] pos,
   output logic              wrap_pulse
);
   localparam int POS_W = FRAC_W + 2;
   localparam logic [POS_W:0]   ONE_W     = 1;
   localparam logic [POS_W-1:0] RESET_POS = POS_W'(1) << (FRAC_W - 1);

   int unsigned       shift_amt;
   logic [POS_W:0]    step_sz, half, off, tmp, base, moved;
   logic [POS_W-1:0]  snap;

   always_comb begin
      shift_amt = FRAC_W - int'(res);
      step_sz   = ONE_W << shift_amt;
      half      = step_sz >> 1;
      off       = (res == RES_FULL2) ? half : '0;
      tmp       = {1'b0, pos} - off + half;
      snap      = POS_W'((tmp & ~(step_sz - ONE_W)) + off);
      base      = {1'b0, snap};
      moved     = dir_rev ? (base - step_sz) : (base + step_sz);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos        <= RESET_POS;
         wrap_pulse <= 1'b0;
      end else if (enable) begin
         pos        <= fire ? moved[POS_W-1:0] : snap;
         wrap_pulse <= fire & moved[POS_W];
      end else begin
         wrap_pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/ustep_phase_dec.sv
module ustep_phase_dec #(
   parameter int FRAC_W = 4
) (
   input  logic [FRAC_W+1:0] angle,
   input  logic              enable,
   input  logic              full_cur,
   output logic              on,
   output logic              neg,
   output logic [FRAC_W-1:0] level
);
   localparam logic [FRAC_W:0] IDX_FULL = {1'b1, {FRAC_W{1'b0}}};
   localparam logic [FRAC_W:0] IDX_ONE  = 1;

   logic [1:0]        quad;
   logic [FRAC_W:0]   frac, idx;

   always_comb begin
      quad  = angle[FRAC_W+1:FRAC_W];
      frac  = {1'b0, angle[FRAC_W-1:0]};
      idx   = quad[0] ? frac : (IDX_FULL - frac);
      on    = enable && (idx != '0);
      neg   = on && (quad[1] ^ quad[0]);
      if (!on)          level = '0;
      else if (full_cur) level = '1;
      else              level = FRAC_W'(idx - IDX_ONE);
   end
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
   import ustep_pkg::*;
#(
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_in,
   input  logic              dir_in,
   input  logic [2:0]        mode_sel,
   input  logic              enable,
   output logic              pha_neg,
   output logic              pha_on,
   output logic [FRAC_W-1:0] pha_level,
   output logic              phb_neg,
   output logic              phb_on,
   output logic [FRAC_W-1:0] phb_level,
   output logic              mon_pulse
);
   localparam int POS_W   = FRAC_W + 2;
   localparam int QUARTER = 1 << FRAC_W;

   if (FRAC_W < 4 || FRAC_W > 8) begin : g_bad_frac
      $error("FRAC_W must lie in 4..8");
   end

   res_e              res;
   logic              full_cur, both_edges, fire, full_q;
   logic [POS_W-1:0]  pos;
   logic [NUM_PHASE-1:0] on_v, neg_v;
   logic [FRAC_W-1:0] lvl_v [NUM_PHASE];

   ustep_mode_dec u_mode (
      .mode_sel  (mode_sel),
      .res       (res),
      .full_cur  (full_cur),
      .both_edges(both_edges)
   );

   ustep_step_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_in   (step_in),
      .both_edges(both_edges),
      .enable    (enable),
      .fire      (fire)
   );

   ustep_position #(.FRAC_W(FRAC_W)) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .fire      (fire),
      .dir_rev   (dir_in),
      .res       (res),
      .pos       (pos),
      .wrap_pulse(mon_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full_q <= 1'b0;
      else if (enable) full_q <= full_cur;
   end

   for (genvar g = 0; g < NUM_PHASE; g++) begin : g_phase
      ustep_phase_dec #(.FRAC_W(FRAC_W)) u_dec (
         .angle   (pos - POS_W'(g * QUARTER)),
         .enable  (enable),
         .full_cur(full_q),
         .on      (on_v[g]),
         .neg     (neg_v[g]),
         .level   (lvl_v[g])
      );
   end

   assign pha_on    = on_v[0];
   assign pha_neg   = neg_v[0];
   assign pha_level = lvl_v[0];
   assign phb_on    = on_v[1];
   assign phb_neg   = neg_v[1];
   assign phb_level = lvl_v[1];
endmodule

// File: rtl/ustep_sequencer_chk.sv
module ustep_sequencer_chk
   import ustep_pkg::*;
#(
   parameter int FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              pha_on,
   input logic              phb_on,
   input logic [FRAC_W-1:0] pha_level,
   input logic [FRAC_W-1:0] phb_level,
   input logic              full_q,
   input logic [FRAC_W+1:0] pos,
   input res_e              res,
   input logic              mon_pulse
);
   localparam int POS_W = FRAC_W + 2;

   function automatic logic on_grid(logic [POS_W-1:0] p, res_e r);
      logic [POS_W-1:0] m, o;
      m = (POS_W'(1) << (FRAC_W - int'(r))) - POS_W'(1);
      o = (r == RES_FULL2) ? (POS_W'(1) << (FRAC_W - 1)) : '0;
      return ((p - o) & m) == '0;
   endfunction

   AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!pha_on && !phb_on && pha_level == '0 && phb_level == '0)); // R8
   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(pos)); // R8
   AST_GRID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enable) |-> on_grid(pos, $past(res))); // R7
   AST_MON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mon_pulse |=> !mon_pulse); // R10
   AST_MON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      mon_pulse |-> $past(enable)); // R10
   AST_WINDING_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (pha_on || phb_on)); // R4
   AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && pha_on) |-> pha_level == '1); // R5
endmodule

bind ustep_sequencer ustep_sequencer_chk #(.FRAC_W(FRAC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .pha_on   (pha_on),
   .phb_on   (phb_on),
   .pha_level(pha_level),
   .phb_level(phb_level),
   .full_q   (full_q),
   .pos      (pos),
   .res      (res),
   .mon_pulse(mon_pulse)
);

// File: tb/ustep_sequencer_test.sv
`timescale 1ns/100ps
module ustep_sequencer_test;
   logic clk = 1'b0, rst_n = 1'b0, step_in = 1'b0, dir_in = 1'b0, enable = 1'b1;
   logic [2:0] mode_sel = 3'b100;
   logic pha_neg, pha_on, phb_neg, phb_on, mon_pulse;
   logic [3:0] pha_level, phb_level;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   string tag = "R9";

   // behavioural reference state
   int m_pos = 8, m_prev = 0, m_mon = 0, m_full = 0;

   always #2 clk = ~clk;

   ustep_sequencer uut (
      .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
      .mode_sel(mode_sel), .enable(enable),
      .pha_neg(pha_neg), .pha_on(pha_on), .pha_level(pha_level),
      .phb_neg(phb_neg), .phb_on(phb_on), .phb_level(phb_level),
      .mon_pulse(mon_pulse)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_idx(int ang);
      int q = ang / 16;
      int f = ang % 16;
      return (q % 2 == 1) ? f : 16 - f;
   endfunction

   function automatic int ref_neg(int ang);
      int q = ang / 16;
      return (q == 1 || q == 2) ? 1 : 0;
   endfunction

   // reference update at each rising edge
   always @(posedge clk) begin
      int res, s, off, sn, np, fire;
      cyc++;
      if (!rst_n) begin
         m_pos = 8; m_prev = 0; m_mon = 0; m_full = 0;
      end else begin
         m_mon = 0;
         if (enable) begin
            res = mode_sel[2] ? int'(mode_sel[1:0]) : int'(mode_sel[1:0]) + 1;
            s   = 16 >> res;
            off = (res == 0) ? 8 : 0;
            sn  = (((m_pos - off + s / 2) / s) * s + off) % 64;
            if (mode_sel[2]) fire = (step_in && m_prev == 0) ? 1 : 0;
            else             fire = (int'(step_in) != m_prev) ? 1 : 0;
            if (fire == 1) begin
               np    = sn + (dir_in ? -s : s);
               m_mon = (np < 0 || np > 63) ? 1 : 0;
               m_pos = (np + 64) % 64;
            end else begin
               m_pos = sn;
            end
            m_full = (mode_sel[2] && !mode_sel[1]) ? 1 : 0;
         end
         m_prev = int'(step_in);
      end
   end

   // compare one ns after each rising edge, every cycle
   always @(posedge clk) begin
      int ia, ib, ea_on, eb_on;
      #1;
      if (rst_n && !done) begin
         ia = enable ? ref_idx(m_pos) : 0;
         ib = enable ? ref_idx((m_pos + 48) % 64) : 0;
         ea_on = (ia != 0) ? 1 : 0;
         eb_on = (ib != 0) ? 1 : 0;
         chk(tag, "pha_on", int'(pha_on), ea_on);
         chk(tag, "phb_on", int'(phb_on), eb_on);
         chk(tag, "pha_level", int'(pha_level), ea_on ? (m_full ? 15 : ia - 1) : 0);
         chk(tag, "phb_level", int'(phb_level), eb_on ? (m_full ? 15 : ib - 1) : 0);
         chk(tag, "pha_neg", int'(pha_neg), ea_on ? ref_neg(m_pos) : 0);
         chk(tag, "phb_neg", int'(phb_neg), eb_on ? ref_neg((m_pos + 48) % 64) : 0);
         chk("R10", "mon_pulse", int'(mon_pulse), m_mon);
      end
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic toggles(int n);
      repeat (n) begin
         @(negedge clk);
         step_in = ~step_in;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic set_mode(logic [2:0] m, int wait_cyc);
      @(negedge clk);
      mode_sel = m;
      repeat (wait_cyc) @(negedge clk);
   endtask

   task automatic reset_check();
      // R9: held reset gives position 8 on both windings
      chk("R9", "pha_on reset", int'(pha_on), 1);
      chk("R9", "pha_level reset", int'(pha_level), 7);
      chk("R9", "pha_neg reset", int'(pha_neg), 0);
      chk("R9", "phb_on reset", int'(phb_on), 1);
      chk("R9", "phb_level reset", int'(phb_level), 7);
      chk("R9", "phb_neg reset", int'(phb_neg), 0);
      chk("R9", "mon_pulse reset", int'(mon_pulse), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      reset_check();
      rst_n = 1'b1;

      tag = "R1";   // rising-only stepping, 2-phase then coarse modes
      toggles(12);
      set_mode(3'b110, 2); toggles(20);
      set_mode(3'b111, 2); toggles(20);

      tag = "R2";   // both-edge stepping
      set_mode(3'b000, 2); toggles(12);
      set_mode(3'b001, 2); toggles(12);
      set_mode(3'b010, 2); toggles(12);

      tag = "R3";   // finest resolution covers all 64 positions
      set_mode(3'b011, 2); toggles(70);

      tag = "R4";
      toggles(64);

      tag = "R5";   // full-current modes
      set_mode(3'b101, 2); toggles(10);
      set_mode(3'b100, 2); toggles(8);

      tag = "R6";   // reverse direction
      dir_in = 1'b1;
      set_mode(3'b011, 2); toggles(40);
      set_mode(3'b100, 2); toggles(8);
      set_mode(3'b001, 2); toggles(10);

      tag = "R7";   // mode switches from off-grid positions, ties, same-cycle steps
      dir_in = 1'b0;
      set_mode(3'b011, 2); toggles(3);
      set_mode(3'b100, 3);
      set_mode(3'b011, 2); toggles(4);
      set_mode(3'b010, 3);
      set_mode(3'b011, 2); toggles(5);
      set_mode(3'b001, 3);
      @(negedge clk); mode_sel = 3'b011; step_in = ~step_in;
      repeat (2) @(negedge clk);
      @(negedge clk); mode_sel = 3'b100; step_in = ~step_in;
      repeat (3) @(negedge clk);
      set_mode(3'b011, 2); toggles(2);
      @(negedge clk); mode_sel = 3'b110; step_in = ~step_in;
      repeat (3) @(negedge clk);

      tag = "R10";  // wraps both ways
      set_mode(3'b011, 2); toggles(130);
      dir_in = 1'b1; toggles(70);
      set_mode(3'b100, 2); toggles(10);

      tag = "R8";   // freeze while disabled
      dir_in = 1'b0;
      set_mode(3'b011, 2); toggles(3);
      @(negedge clk); enable = 1'b0;
      toggles(7);
      set_mode(3'b100, 3);
      dir_in = 1'b1;
      set_mode(3'b110, 3);
      @(negedge clk); enable = 1'b1;
      repeat (4) @(negedge clk);
      toggles(6);

      tag = "R11";
      set_mode(3'b011, 1); toggles(9);

      tag = "R9";   // reset in the middle of a run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      reset_check();
      rst_n = 1'b1;
      toggles(6);

      repeat (4) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule